// File: doc/BRIEF.md
# DVMA Page Table Walker

This block turns a device virtual address into a 36-bit physical address. It uses a single-level translation table that sits in main memory. Requests are handled one at a time. For each request the block reads one 32-bit table entry over a valid/ready memory read port. It then checks the entry's permission bits against the direction of the access. There is no translation cache, so every request costs exactly one table read.

The translation window is picked by a 3-bit range code and starts at the top of the 32-bit virtual space. Any virtual address bits above the window are removed before the table is indexed. The table base and the range code are sampled in the cycle a request is accepted, so software may change them while a walk is in progress.

Each response reports one of two outcomes with a fault flag. A successful walk returns the physical address. A fault returns the page-aligned virtual address. Both outcomes carry the direction of the access.

Top module: `dvma_walker`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, while `rsp_valid` and `mem_req_valid` are 0.
- R2: The window start is all-ones shifted left by 24 plus `cfg_range`, so code 0 selects a 16 MB window and code 7 selects a 2 GB window. Virtual address bits at or above the window start do not affect the table index.
- R3: The entry address on `mem_req_addr` is `{cfg_base, 4'b0000}` plus the windowed virtual address shifted right by 10 with its two low bits cleared. `cfg_base` and `cfg_range` are sampled when the request is accepted. The address is held stable until `mem_req_ready`, and exactly one read is issued per request.
- R4: A walk with no fault returns `rsp_addr = {entry[31:8], vaddr[11:0]}` with `rsp_fault = 0`. Entry bits 7 (cacheable), 6:3 and 0 (write-as-zero) have no effect.
- R5: An entry whose bit 1 (valid) is 0 faults, for reads and for writes.
- R6: A write (`req_write = 1`) faults when entry bit 2 (write enable) is 0. A read ignores bit 2.
- R7: A memory response with `mem_rsp_err = 1` faults, whatever the entry value. The fault response appears two cycles after the memory handshake.
- R8: A fault response carries `rsp_fault = 1` and `rsp_addr = {4'h0, vaddr[31:12], 12'h000}`. Every response sets `rsp_write` equal to the request's `req_write`.
- R9: `req_ready` stays 0 from acceptance until the response handshake. While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_fault`, `rsp_addr` and `rsp_write` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | 32 | Table base, scaled by 16 to form a byte address |
| cfg_range | input | 3 | Window size code, 16 MB << code |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Device virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 36 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_ready | output | 1 | Walker waiting for entry data |
| mem_rsp_data | input | 32 | Table entry |
| mem_rsp_err | input | 1 | Memory reported an error for the read |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer accepts the result |
| rsp_fault | output | 1 | 1 = fault, `rsp_addr` is the faulting page |
| rsp_addr | output | 36 | Physical address, or fault page address |
| rsp_write | output | 1 | Direction of the request that produced this result |

## Verification
A walker stuck in the wrong state shows up at the ports within a cycle. A second request would be taken while a result is pending, a second memory read would be issued, or a result would appear without a memory handshake. A wrong latched request field shows up as a bad entry address at the very next `mem_req_valid`, or as a wrong direction or page in the matching response. A wrong permission decision turns into a success/fault mismatch two cycles after the memory data arrives. The scoreboard pairs every response with its request in order, so a lost or duplicated response shows up as a queue mismatch.

// File: rtl/dvma_pkg.sv
package dvma_pkg;

  // Walk sequencing
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_AWAIT = 3'd2,
    ST_CHECK = 3'd3,
    ST_DONE  = 3'd4,
    ST_FAULT = 3'd5
  } walk_state_e;

  // Table entry field positions
  localparam int unsigned ENT_PPN_LSB  = 8;
  localparam int unsigned ENT_WREN_BIT = 2;
  localparam int unsigned ENT_VLD_BIT  = 1;

  // Scale of the base register and of the table index
  localparam int unsigned BASE_SCALE_SHIFT = 4;
  localparam int unsigned ENT_BYTES_LOG2   = 2;

endpackage

// File: rtl/dvma_ent_addr.sv
module dvma_ent_addr
  import dvma_pkg::*;
#(
  parameter int unsigned VA_W          = 32,
  parameter int unsigned RANGE_W       = 3,
  parameter int unsigned WIN_MIN_SHIFT = 24,
  parameter int unsigned PAGE_SHIFT    = 12,
  parameter int unsigned ADDR_W        = VA_W + BASE_SCALE_SHIFT
) (
  input  logic [VA_W-1:0]    base,
  input  logic [RANGE_W-1:0] range_code,
  input  logic [VA_W-1:0]    vaddr,
  output logic [ADDR_W-1:0]  ent_addr
);

  localparam int unsigned IDX_SHIFT = PAGE_SHIFT - ENT_BYTES_LOG2;

  logic [VA_W-1:0] win_start;
  logic [VA_W-1:0] in_window;
  logic [VA_W-1:0] byte_index;

  always_comb begin
    win_start  = {VA_W{1'b1}} << (WIN_MIN_SHIFT + 32'(range_code));
    in_window  = vaddr & ~win_start;
    byte_index = (in_window >> IDX_SHIFT) & ~VA_W'((1 << ENT_BYTES_LOG2) - 1);
    ent_addr   = {base, {BASE_SCALE_SHIFT{1'b0}}} + ADDR_W'(byte_index);
  end

endmodule

// File: rtl/dvma_ent_check.sv
module dvma_ent_check
  import dvma_pkg::*;
#(
  parameter int unsigned VA_W       = 32,
  parameter int unsigned ENT_W      = 32,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned ADDR_W     = 36
) (
  input  logic [ENT_W-1:0]  entry,
  input  logic              mem_err,
  input  logic              is_write,
  input  logic [VA_W-1:0]   vaddr,
  output logic              fault,
  output logic [ADDR_W-1:0] result_addr
);

  localparam int unsigned PPN_W = ENT_W - ENT_PPN_LSB;

  logic             ent_valid;
  logic             ent_wren;
  logic [PPN_W-1:0] ppn;
  logic [ADDR_W-1:0] phys_addr;
  logic [ADDR_W-1:0] page_addr;
  logic             unused_attr_bits;

  assign ent_valid        = entry[ENT_VLD_BIT];
  assign ent_wren         = entry[ENT_WREN_BIT];
  assign ppn              = entry[ENT_W-1:ENT_PPN_LSB];
  assign unused_attr_bits = ^{entry[ENT_PPN_LSB-1:ENT_WREN_BIT+1], entry[0]};

  always_comb begin
    fault     = mem_err || !ent_valid || (is_write && !ent_wren);
    phys_addr = ADDR_W'({ppn, vaddr[PAGE_SHIFT-1:0]});
    page_addr = ADDR_W'({vaddr[VA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}});
    result_addr = fault ? page_addr : phys_addr;
  end

endmodule

// File: rtl/dvma_walk_fsm.sv
module dvma_walk_fsm
  import dvma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic mem_req_ready,
  input  logic mem_rsp_valid,
  input  logic rsp_ready,
  input  logic check_fault,
  output logic req_ready,
  output logic load_req,
  output logic mem_req_valid,
  output logic mem_rsp_ready,
  output logic cap_entry,
  output logic load_result,
  output logic rsp_valid,
  output logic rsp_fault
);

  walk_state_e state_q;
  walk_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid)     state_d = ST_FETCH;
      ST_FETCH: if (mem_req_ready) state_d = ST_AWAIT;
      ST_AWAIT: if (mem_rsp_valid) state_d = ST_CHECK;
      ST_CHECK: state_d = check_fault ? ST_FAULT : ST_DONE;
      ST_DONE,
      ST_FAULT: if (rsp_ready)     state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    req_ready     = (state_q == ST_IDLE);
    load_req      = req_ready && req_valid;
    mem_req_valid = (state_q == ST_FETCH);
    mem_rsp_ready = (state_q == ST_AWAIT);
    cap_entry     = mem_rsp_ready && mem_rsp_valid;
    load_result   = (state_q == ST_CHECK);
    rsp_valid     = (state_q == ST_DONE) || (state_q == ST_FAULT);
    rsp_fault     = (state_q == ST_FAULT);
  end

endmodule

// File: rtl/dvma_walker.sv
module dvma_walker
  import dvma_pkg::*;
#(
  parameter int unsigned VA_W          = 32,
  parameter int unsigned ENT_W         = 32,
  parameter int unsigned RANGE_W       = 3,
  parameter int unsigned WIN_MIN_SHIFT = 24,
  parameter int unsigned PAGE_SHIFT    = 12,
  parameter int unsigned ADDR_W        = VA_W + BASE_SCALE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VA_W-1:0]   cfg_base,
  input  logic [RANGE_W-1:0] cfg_range,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_write,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [ENT_W-1:0]  mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_fault,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_write
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Control
  logic load_req, cap_entry, load_result, check_fault;

  dvma_walk_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .req_valid    (req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid),
    .rsp_ready    (rsp_ready),
    .check_fault  (check_fault),
    .req_ready    (req_ready),
    .load_req     (load_req),
    .mem_req_valid(mem_req_valid),
    .mem_rsp_ready(mem_rsp_ready),
    .cap_entry    (cap_entry),
    .load_result  (load_result),
    .rsp_valid    (rsp_valid),
    .rsp_fault    (rsp_fault)
  );

  // Entry address, computed from the live request and configuration
  logic [ADDR_W-1:0] ent_addr_d;

  dvma_ent_addr #(
    .VA_W         (VA_W),
    .RANGE_W      (RANGE_W),
    .WIN_MIN_SHIFT(WIN_MIN_SHIFT),
    .PAGE_SHIFT   (PAGE_SHIFT),
    .ADDR_W       (ADDR_W)
  ) u_addr (
    .base      (cfg_base),
    .range_code(cfg_range),
    .vaddr     (req_vaddr),
    .ent_addr  (ent_addr_d)
  );

  // Request registers, loaded on acceptance
  logic [VA_W-1:0]   va_q;
  logic              wr_q;
  logic [ADDR_W-1:0] ent_addr_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      va_q       <= '0;
      wr_q       <= 1'b0;
      ent_addr_q <= '0;
    end else if (load_req) begin
      va_q       <= req_vaddr;
      wr_q       <= req_write;
      ent_addr_q <= ent_addr_d;
    end
  end

  // Entry capture
  logic [ENT_W-1:0] ent_q;
  logic             err_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ent_q <= '0;
      err_q <= 1'b0;
    end else if (cap_entry) begin
      ent_q <= mem_rsp_data;
      err_q <= mem_rsp_err;
    end
  end

  // Permission check and address formation
  logic [ADDR_W-1:0] result_d;

  dvma_ent_check #(
    .VA_W      (VA_W),
    .ENT_W     (ENT_W),
    .PAGE_SHIFT(PAGE_SHIFT),
    .ADDR_W    (ADDR_W)
  ) u_check (
    .entry      (ent_q),
    .mem_err    (err_q),
    .is_write   (wr_q),
    .vaddr      (va_q),
    .fault      (check_fault),
    .result_addr(result_d)
  );

  // Result register
  logic [ADDR_W-1:0] result_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)       result_q <= '0;
    else if (load_result) result_q <= result_d;
  end

  assign mem_req_addr = ent_addr_q;
  assign rsp_addr     = result_q;
  assign rsp_write    = wr_q;

endmodule

// File: rtl/dvma_walker_chk.sv
module dvma_walker_chk #(
  parameter int unsigned VA_W    = 32,
  parameter int unsigned ENT_W   = 32,
  parameter int unsigned RANGE_W = 3,
  parameter int unsigned ADDR_W  = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              mem_rsp_ready,
  input logic              mem_rsp_err,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_fault,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic              rsp_write
);

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_fault) &&
                                   $stable(rsp_addr) && $stable(rsp_write)));

  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_req_valid || mem_rsp_ready) |-> !req_ready);

  p_memreq_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_one_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

  p_fault_page_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_addr[11:0] == 12'h000 && rsp_addr[ADDR_W-1:VA_W] == '0));

  p_err_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid && mem_rsp_ready && mem_rsp_err) |=> ##1 (rsp_valid && rsp_fault));

  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

endmodule

bind dvma_walker dvma_walker_chk #(
  .VA_W(VA_W), .ENT_W(ENT_W), .RANGE_W(RANGE_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/dvma_walker_test.sv
module dvma_walker_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] cfg_base;
  logic [2:0]  cfg_range;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_vaddr;
  logic        req_write;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [35:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic        mem_rsp_ready;
  logic [31:0] mem_rsp_data;
  logic        mem_rsp_err;
  logic        rsp_valid;
  logic        rsp_ready;
  logic        rsp_fault;
  logic [35:0] rsp_addr;
  logic        rsp_write;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  // Scoreboard
  logic        exp_fault_q[$];
  logic [35:0] exp_addr_q[$];
  logic        exp_wr_q[$];
  string       exp_tag_q[$];

  always #10 clk = ~clk;

  dvma_walker uut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [35:0] got, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // Independent model of the requirements
  function automatic logic [35:0] model_ent_addr(input logic [31:0] base,
                                                 input logic [2:0] rng,
                                                 input logic [31:0] va);
    logic [31:0] win;
    logic [31:0] idx;
    win = 32'hFFFF_FFFF << (24 + int'(rng));             // R2
    idx = ((va & ~win) >> 10) & 32'hFFFF_FFFC;            // R3
    return {base, 4'h0} + {4'h0, idx};
  endfunction

  task automatic walk(input logic [31:0] va, input bit wr, input logic [31:0] base,
                      input logic [2:0] rng, input logic [31:0] ent, input bit err,
                      input int lat, input string tag);
    logic        f;
    logic [35:0] ea;
    ea = model_ent_addr(base, rng, va);
    f  = err || !ent[1] || (wr && !ent[2]);               // R5 R6 R7
    exp_fault_q.push_back(f);
    exp_addr_q.push_back(f ? {4'h0, va[31:12], 12'h000} : {ent[31:8], va[11:0]});
    exp_wr_q.push_back(wr);
    exp_tag_q.push_back(tag);

    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cfg_base  = base;
    cfg_range = rng;
    req_vaddr = va;
    req_write = wr;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cfg_base  = ~base;                                    // R3: sampled at accept
    cfg_range = rng + 3'd3;
    req_vaddr = ~va;
    req_write = ~wr;
    while (!mem_req_valid) @(negedge clk);
    check(mem_req_addr == ea, "R3", {tag, " entry address"}, mem_req_addr, ea);
    for (int i = 0; i < lat; i++) @(negedge clk);
    check(mem_req_valid && mem_req_addr == ea, "R3", {tag, " held request"}, mem_req_addr, ea);
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    check(!mem_req_valid, "R3", {tag, " single read"}, 36'(mem_req_valid), 36'h0);
    for (int i = 0; i < lat; i++) @(negedge clk);
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = ent;
    mem_rsp_err   = err;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = 32'hDEAD_BEEF;
    mem_rsp_err   = 1'b1;
  endtask

  // Consumer back-pressure
  initial begin
    rsp_ready = 1'b0;
    forever begin
      @(posedge clk);
      #3;
      cyc++;
      rsp_ready = (cyc % 3) != 1;
    end
  end

  // Monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid) begin
        check(!req_ready, "R9", "ready while result pending", 36'(req_ready), 36'h0);
        if (rsp_ready) begin
          if (exp_fault_q.size() == 0) begin
            check(1'b0, "R9", "unexpected response", rsp_addr, 36'h0);
          end else begin
            logic        ef;
            logic [35:0] ea;
            logic        ew;
            string       t;
            ef = exp_fault_q.pop_front();
            ea = exp_addr_q.pop_front();
            ew = exp_wr_q.pop_front();
            t  = exp_tag_q.pop_front();
            check(rsp_fault == ef, t, "fault flag", 36'(rsp_fault), 36'(ef));
            check(rsp_addr == ea, t, "address", rsp_addr, ea);
            check(rsp_write == ew, "R8", {t, " direction"}, 36'(rsp_write), 36'(ew));
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_base = '0; cfg_range = '0;
    req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0; mem_rsp_err = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(req_ready && !rsp_valid && !mem_req_valid, "R1", "idle after reset",
          {33'h0, req_ready, rsp_valid, mem_req_valid}, 36'h4);

    // R4: plain read with attribute bits set, no effect on the result
    walk(32'hFF12_3456, 1'b0, 32'h0012_3400, 3'd0, 32'hABCD_EF83, 1'b0, 0, "R4");
    // R4: write with permission, 2 GB window
    walk(32'h8765_4ABC, 1'b1, 32'h0000_1000, 3'd7, 32'h1234_5606, 1'b0, 2, "R4");
    // R2: bits above a 64 MB window ignored
    walk(32'hFD7F_F123, 1'b0, 32'h0040_0000, 3'd2, 32'h00F0_0002, 1'b0, 1, "R2");
    walk(32'h017F_F123, 1'b0, 32'h0040_0000, 3'd2, 32'h00F0_0002, 1'b0, 0, "R2");
    // R5: invalid entry, both directions
    walk(32'hFF00_1FFF, 1'b0, 32'h0000_2000, 3'd0, 32'hFFFF_FF05, 1'b0, 0, "R5");
    walk(32'hF0AB_C010, 1'b1, 32'h0000_2000, 3'd4, 32'h1111_1104, 1'b0, 3, "R5");
    // R6: write without permission faults, read with the same entry succeeds
    walk(32'hC123_4567, 1'b1, 32'h0765_4321, 3'd6, 32'h5555_5503, 1'b0, 1, "R6");
    walk(32'hC123_4567, 1'b0, 32'h0765_4321, 3'd6, 32'h5555_5503, 1'b0, 1, "R6");
    // R7: memory error with an otherwise valid, writable entry
    walk(32'hE000_0FFC, 1'b1, 32'h0001_0000, 3'd5, 32'h7777_7786, 1'b1, 0, "R7");
    walk(32'hFF00_0000, 1'b0, 32'hFFFF_FFFF, 3'd0, 32'h0000_0106, 1'b1, 2, "R7");
    // R8: fault address page-aligned at the top of the space
    walk(32'hFFFF_FFFF, 1'b0, 32'h0000_0000, 3'd3, 32'h0000_0000, 1'b0, 0, "R8");
    // R4: largest base, carry into the upper address bits
    walk(32'hFFFF_F001, 1'b1, 32'hFFFF_FFF0, 3'd1, 32'hFFFF_FF06, 1'b0, 0, "R4");

    while (exp_fault_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(req_ready && !rsp_valid, "R9", "idle after last response",
          {34'h0, req_ready, rsp_valid}, 36'h2);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule